// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Generator

This block drives two pulse-width-modulated outputs that share one pulse width and one period. The pulses on the second output start half a period after those on the first. It is meant for two switches that must take turns and must never both be on. The second output is a half-period-shifted copy of the first, not its inverse. At any duty below the ceiling, both outputs rest low for part of every half-period.

A single counter runs through the period. The pulse width is limited so that each pulse ends at least a programmable number of cycles before the other output's pulse begins. Period, duty and gap settings are taken into shadow registers only when the counter wraps, or at any time while the block is disabled or in reset. A new setting therefore never cuts a pulse short in the middle of a period. Both outputs come straight from flip-flops.

Top module: `interleaved_pwm`

## Requirements
- R1: While `rst` is high or `en` is low, at each clock edge both outputs go low and the count returns to 0. The first enabled edge starts the count at 0.
- R2: The count runs from 0 to P-1 and then wraps to 0, where P is the period setting or 2 if the setting is below 2. `pha` is high in the cycle after each edge at which the count is below the effective duty D.
- R3: `phb` is high in the cycle after each edge at which the count lies in [H, H+D), where H = floor(P/2).
- R4: D is the duty setting limited to H minus the gap setting. D is 0 when the gap setting is H or more.
- R5: `pha` and `phb` are never high in the same cycle.
- R6: Each rising edge of either output that follows an earlier pulse comes after at least as many both-low cycles as the gap setting that governed that earlier pulse.
- R7: Period, duty and gap inputs take effect only at the edge where the count wraps from P-1 to 0, or at any edge while disabled or in reset. Changes at other times do not alter the current period.
- R8: An effective duty of 0 keeps both outputs low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces outputs low |
| period | input | CW | Period in clock cycles |
| duty | input | CW | Requested pulse width in cycles |
| dead | input | CW | Minimum both-low gap in cycles |
| pha | output | 1 | Phase A pulse output |
| phb | output | 1 | Phase B pulse output, half a period later |

## Verification
The hardest case to reach from the ports is a settings change that lands in the middle of a period. In that case the old shadow values must go on shaping the current pulses, while the next period uses the new ones. The stimulus changes period, duty and gap at a fixed phase that does not match the counter's wrap. It does this with odd and even periods, with the clamp both active and inactive, and with a gap that grows from zero. A behavioural model is compared on every cycle, so any early capture shows up as a mismatch.

// File: rtl/interleaved_pwm.sv
module interleaved_pwm #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] dead,
  output logic          pha,
  output logic          phb
);

  localparam logic [CW-1:0] MIN_P = CW'(2);

  logic [CW-1:0] cnt, p_s, h_s, d_s, g_s;
  logic [CW-1:0] p_in, h_in, lim_in, d_in;
  logic          idle, wrap;

  assign p_in   = (period < MIN_P) ? MIN_P : period;
  assign h_in   = p_in >> 1;
  assign lim_in = (h_in > dead) ? h_in - dead : '0;
  assign d_in   = (duty < lim_in) ? duty : lim_in;

  assign idle = rst || !en;
  assign wrap = (cnt == p_s - 1'b1);

  always_ff @(posedge clk) begin
    if (idle || wrap) begin
      p_s <= p_in;
      h_s <= h_in;
      d_s <= d_in;
      g_s <= dead;
    end
    if (idle) begin
      cnt <= '0;
      pha <= 1'b0;
      phb <= 1'b0;
    end else begin
      pha <= (cnt < d_s);
      phb <= (cnt >= h_s) && ((cnt - h_s) < d_s);
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // gap tracking for the dead-time property
  logic [CW:0]   low_run;
  logic [CW-1:0] gap_req;

  always_ff @(posedge clk) begin
    if (idle) begin
      low_run <= '0;
      gap_req <= '0;
    end else begin
      if (pha || phb) low_run <= '0;
      else if (!(&low_run)) low_run <= low_run + 1'b1;
      if ((pha || phb) && cnt != '0) gap_req <= g_s;
    end
  end

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst) !(pha && phb));

  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pha && !phb && cnt == '0));

  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    en |-> cnt < p_s);

  a_r6_gap_a: assert property (@(posedge clk) disable iff (rst)
    $rose(pha) |-> low_run >= {1'b0, gap_req});

  a_r6_gap_b: assert property (@(posedge clk) disable iff (rst)
    $rose(phb) |-> low_run >= {1'b0, gap_req});

  a_r7_hold_mid: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && cnt != '0) |-> $stable(d_s) && $stable(p_s));

  a_r8_zero_duty: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $past(d_s) == '0 && d_s == '0) |-> !pha && !phb);

endmodule

// File: tb/interleaved_pwm_bench.sv
`timescale 1ns/1ps
module interleaved_pwm_bench;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst, en;
  logic [CW-1:0] period, duty, dead;
  logic pha, phb;

  interleaved_pwm #(.CW(CW)) u_interleaved_pwm (
    .clk(clk), .rst(rst), .en(en), .period(period), .duty(duty),
    .dead(dead), .pha(pha), .phb(phb)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural reference
  int m = 0, sp = 2, sh = 1, sd = 0;
  bit ea = 0, eb = 0;

  task automatic take();
    int p, h, l;
    p = (period < 2) ? 2 : int'(period);
    h = p / 2;
    l = (h > int'(dead)) ? h - int'(dead) : 0;
    sp = p; sh = h; sd = (int'(duty) < l) ? int'(duty) : l;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst || !en) begin
      m = 0; ea = 0; eb = 0; take();
    end else begin
      ea = (m < sd);
      eb = (m >= sh) && (m < sh + sd);
      if (m == sp - 1) begin m = 0; take(); end
      else m++;
    end
  end

  always @(negedge clk) begin
    if (!done && cyc > 1) begin
      checks++;
      if (pha !== ea) begin
        errors++;
        $display("FAIL R2 pha cycle %0d: got %b expected %b", cyc, pha, ea);
      end
      checks++;
      if (phb !== eb) begin
        errors++;
        $display("FAIL R3 phb cycle %0d: got %b expected %b", cyc, phb, eb);
      end
      checks++;
      if (pha === 1'b1 && phb === 1'b1) begin
        errors++;
        $display("FAIL R5 overlap cycle %0d: got 11 expected not both high", cyc);
      end
    end
  end

  task automatic cfg(input int p, input int d, input int g);
    period = CW'(p); duty = CW'(d); dead = CW'(g);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic point(input string tag, input bit a, input bit b);
    checks++;
    if (pha !== a || phb !== b) begin
      errors++;
      $display("FAIL %s: got %b%b expected %b%b", tag, pha, phb, a, b);
    end
  endtask

  initial begin
    rst = 1; en = 0; cfg(20, 5, 2);
    run(3);
    point("R1 reset low", 0, 0);
    rst = 0; run(2);
    point("R1 disabled low", 0, 0);
    en = 1;
    @(negedge clk);
    point("R1 first enabled edge raises A", 1, 0);
    run(60);
    cfg(20, 9, 2);                 // R4 clamp to 8
    run(47);
    cfg(7, 3, 1);                  // odd period, R4 limit 2
    run(53);
    cfg(10, 4, 0); run(31);        // gap zero
    cfg(10, 5, 0); run(40);        // full half, touching pulses
    cfg(10, 5, 3); run(29);        // R6 gap grows mid-period, R7
    cfg(16, 6, 12); run(48);       // R8 clamp to zero
    point("R8 zero effective duty", 0, 0);
    cfg(12, 0, 1); run(36);
    point("R8 duty zero", 0, 0);
    cfg(1, 3, 0); run(20);         // R2 period floor of 2
    cfg(24, 7, 3); run(33);
    en = 0; @(negedge clk);
    point("R1 disable forces low", 0, 0);
    run(3);
    en = 1; run(45);
    rst = 1; @(negedge clk);
    point("R1 reset mid-run", 0, 0);
    rst = 0; cfg(9, 4, 1); run(50);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule